// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is one output cell of a small sum-of-products programmable logic device. A programmable AND array outside the block produces eight product-term values for the cell. A per-term disable mask removes terms from the OR, and a polarity bit then sets whether the pin is active high or active low. Each cell holds its own configuration. It acts either as a registered output, driven from a shared clock and a shared active-low output enable, or as a combinatorial I/O. In I/O mode one product term serves as the pin's output enable, and the other seven form the sum.

The configuration inputs act like fuses. They are captured only while reset is asserted and hold their values for the rest of operation. A test preload strobe writes a chosen value into the cell register for one cycle in place of the normal next state. The pin is modelled as a value, a drive enable and a separate pin input. A feedback output returns what the cell presents to the array.

Top module: `plc_out_cell`

## Requirements
- R1: After a synchronous reset, the cell register holds 0, so a cell configured as registered shows pad_o = 0 in the first cycle after reset is released.
- R2: In registered mode (cfg_sync_i = 0, cfg_family_i = 1, cfg_io_i = 0), pad_o equals the polarity-adjusted OR of all eight enabled product terms sampled at the previous rising clock edge.
- R3: Polarity bit cfg_pol_i = 1 gives an active-high output (pin = sum). cfg_pol_i = 0 gives an active-low output (pin = NOT sum). This applies in both registered and I/O modes.
- R4: A product term whose bit in the disable mask cfg_pt_dis_i is 1 contributes nothing to the sum, whatever its value.
- R5: In registered mode, pad_oe_o is the inverse of the shared active-low enable oe_n_i in the same cycle.
- R6: In I/O mode (cfg_io_i = 1), pad_o is the polarity-adjusted OR of enabled terms 1 to 7 in the same cycle. Term 0 is not part of the sum.
- R7: In I/O mode, pad_oe_o is 1 exactly when product term 0 is 1 and its disable bit is 0.
- R8: fb_o carries the register value in registered mode. In I/O mode it carries pad_o while the pin is driven and pad_i while it is not.
- R9: While pl_strobe_i is 1 at a rising edge, the register loads pl_data_i in place of the sum.
- R10: Configuration inputs are captured only while rst is 1. Changes to them after reset have no effect on the outputs.
- R11: When the global bits do not select the registered-mode family (cfg_sync_i = 1 or cfg_family_i = 0), the pin is not driven, pad_o is 0 and fb_o follows pad_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared cell clock |
| rst | input | 1 | Synchronous active-high reset; also captures configuration |
| cfg_sync_i | input | 1 | Global sync-mode bit (must be 0 for this family) |
| cfg_family_i | input | 1 | Global family-select bit (must be 1 for this family) |
| cfg_io_i | input | 1 | Per-cell select: 0 registered, 1 combinatorial I/O |
| cfg_pol_i | input | 1 | Polarity: 1 active high, 0 active low |
| cfg_pt_dis_i | input | NUM_TERMS | Per-term disable mask, 1 removes the term |
| pterm_i | input | NUM_TERMS | Product-term values from the AND array |
| oe_n_i | input | 1 | Shared active-low output enable for registered cells |
| pl_strobe_i | input | 1 | Test preload strobe |
| pl_data_i | input | 1 | Test preload value |
| pad_i | input | 1 | Value seen on the pin from outside |
| pad_o | output | 1 | Value the cell drives on the pin |
| pad_oe_o | output | 1 | Pin drive enable |
| fb_o | output | 1 | Feedback to the AND array |

## Verification
The registered sum is driven with an all-zero vector, single-hot vectors at the lowest and highest term, an all-ones vector and a sparse mix, under both polarities. These patterns separate a correct OR from an AND, a dropped end term, or a missing inversion. Disable masks are paired with vectors that are live only in masked or only in unmasked positions. This exposes an ignored mask or an inverted one. In I/O mode, a vector with only term 0 set tells the enable term apart from the sum. The undriven case checks that feedback switches to the pin input.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    CK_OFF  = 2'd0,
    CK_REG  = 2'd1,
    CK_COMB = 2'd2
  } cell_kind_e;
endpackage

// File: rtl/plc_cfg_latch.sv
module plc_cfg_latch
  import plc_pkg::*;
#(
  parameter int NUM_TERMS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_sync_i,
  input  logic                 cfg_family_i,
  input  logic                 cfg_io_i,
  input  logic                 cfg_pol_i,
  input  logic [NUM_TERMS-1:0] cfg_pt_dis_i,
  output cell_kind_e           kind_o,
  output logic                 pol_o,
  output logic [NUM_TERMS-1:0] dis_o
);
  cell_kind_e kind_next;

  always_comb begin
    if (cfg_sync_i || !cfg_family_i) kind_next = CK_OFF;
    else if (cfg_io_i)               kind_next = CK_COMB;
    else                             kind_next = CK_REG;
  end

  // Fuse-like capture: only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) begin
      kind_o <= kind_next;
      pol_o  <= cfg_pol_i;
      dis_o  <= cfg_pt_dis_i;
    end
  end
endmodule

// File: rtl/plc_term_sum.sv
module plc_term_sum #(
  parameter int NUM_TERMS = 8,
  parameter int FIRST     = 0
) (
  input  logic [NUM_TERMS-1:0] pterm_i,
  input  logic [NUM_TERMS-1:0] dis_i,
  input  logic                 pol_i,
  output logic                 val_o
);
  logic [NUM_TERMS-1:0] live;

  for (genvar i = 0; i < NUM_TERMS; i++) begin : g_term
    if (i < FIRST) begin : g_excluded
      assign live[i] = 1'b0 & pterm_i[i] & dis_i[i];
    end else begin : g_included
      assign live[i] = pterm_i[i] & ~dis_i[i];
    end
  end

  // Polarity: 1 keeps the sum, 0 inverts it.
  assign val_o = pol_i ? (|live) : ~(|live);
endmodule

// File: rtl/plc_out_reg.sv
module plc_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  input  logic pl_strobe_i,
  input  logic pl_data_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)              q_o <= 1'b0;
    else if (pl_strobe_i) q_o <= pl_data_i;
    else                  q_o <= d_i;
  end
endmodule

// File: rtl/plc_out_cell.sv
module plc_out_cell
  import plc_pkg::*;
#(
  parameter int NUM_TERMS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_sync_i,
  input  logic                 cfg_family_i,
  input  logic                 cfg_io_i,
  input  logic                 cfg_pol_i,
  input  logic [NUM_TERMS-1:0] cfg_pt_dis_i,
  input  logic [NUM_TERMS-1:0] pterm_i,
  input  logic                 oe_n_i,
  input  logic                 pl_strobe_i,
  input  logic                 pl_data_i,
  input  logic                 pad_i,
  output logic                 pad_o,
  output logic                 pad_oe_o,
  output logic                 fb_o
);
  localparam int OE_TERM    = 0;
  localparam int COMB_FIRST = OE_TERM + 1;

  cell_kind_e           kind_q;
  logic                 pol_q;
  logic [NUM_TERMS-1:0] dis_q;
  logic                 reg_d;
  logic                 reg_q;
  logic                 io_val;
  logic                 io_en;

  plc_cfg_latch #(.NUM_TERMS(NUM_TERMS)) cfg_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_sync_i   (cfg_sync_i),
    .cfg_family_i (cfg_family_i),
    .cfg_io_i     (cfg_io_i),
    .cfg_pol_i    (cfg_pol_i),
    .cfg_pt_dis_i (cfg_pt_dis_i),
    .kind_o       (kind_q),
    .pol_o        (pol_q),
    .dis_o        (dis_q)
  );

  plc_term_sum #(.NUM_TERMS(NUM_TERMS), .FIRST(0)) reg_sum_i (
    .pterm_i (pterm_i),
    .dis_i   (dis_q),
    .pol_i   (pol_q),
    .val_o   (reg_d)
  );

  plc_term_sum #(.NUM_TERMS(NUM_TERMS), .FIRST(COMB_FIRST)) io_sum_i (
    .pterm_i (pterm_i),
    .dis_i   (dis_q),
    .pol_i   (pol_q),
    .val_o   (io_val)
  );

  plc_out_reg reg_i (
    .clk         (clk),
    .rst         (rst),
    .d_i         (reg_d),
    .pl_strobe_i (pl_strobe_i),
    .pl_data_i   (pl_data_i),
    .q_o         (reg_q)
  );

  assign io_en = pterm_i[OE_TERM] & ~dis_q[OE_TERM];

  always_comb begin
    unique case (kind_q)
      CK_REG: begin
        pad_o    = reg_q;
        pad_oe_o = ~oe_n_i;
        fb_o     = reg_q;
      end
      CK_COMB: begin
        pad_o    = io_val;
        pad_oe_o = io_en;
        fb_o     = io_en ? io_val : pad_i;
      end
      default: begin
        pad_o    = 1'b0;
        pad_oe_o = 1'b0;
        fb_o     = pad_i;
      end
    endcase
  end
endmodule

// File: rtl/plc_out_cell_chk.sv
module plc_out_cell_chk
  import plc_pkg::*;
#(
  parameter int NUM_TERMS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input cell_kind_e           kind,
  input logic                 pol,
  input logic [NUM_TERMS-1:0] dis,
  input logic [NUM_TERMS-1:0] pterm_i,
  input logic                 oe_n_i,
  input logic                 pl_strobe_i,
  input logic                 pl_data_i,
  input logic                 pad_i,
  input logic                 pad_o,
  input logic                 pad_oe_o,
  input logic                 fb_o
);
  logic full_or;
  logic io_or;
  assign full_or = |(pterm_i & ~dis);
  assign io_or   = |(pterm_i[NUM_TERMS-1:1] & ~dis[NUM_TERMS-1:1]);

  // R1
  p_reset_zero_r1: assert property (@(posedge clk)
    ($fell(rst) && kind == CK_REG) |-> (pad_o == 1'b0));

  // R2, R3, R4
  p_reg_next_r2: assert property (@(posedge clk) disable iff (rst)
    (kind == CK_REG && !pl_strobe_i) |=> (pad_o == $past(pol ? full_or : ~full_or)));

  // R5
  p_reg_oe_r5: assert property (@(posedge clk) disable iff (rst)
    (kind == CK_REG) |-> (pad_oe_o == !oe_n_i));

  // R6
  p_comb_val_r6: assert property (@(posedge clk) disable iff (rst)
    (kind == CK_COMB) |-> (pad_o == (pol ? io_or : ~io_or)));

  // R7
  p_comb_oe_r7: assert property (@(posedge clk) disable iff (rst)
    (kind == CK_COMB) |-> (pad_oe_o == (pterm_i[0] & ~dis[0])));

  // R8
  p_comb_fb_r8: assert property (@(posedge clk) disable iff (rst)
    (kind == CK_COMB && !pad_oe_o) |-> (fb_o == pad_i));

  // R9
  p_preload_r9: assert property (@(posedge clk) disable iff (rst)
    (kind == CK_REG && pl_strobe_i) |=> (pad_o == $past(pl_data_i)));

  // R11
  p_off_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (kind == CK_OFF) |-> (!pad_oe_o && !pad_o && fb_o == pad_i));
endmodule

bind plc_out_cell plc_out_cell_chk #(.NUM_TERMS(NUM_TERMS)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .kind        (kind_q),
  .pol         (pol_q),
  .dis         (dis_q),
  .pterm_i     (pterm_i),
  .oe_n_i      (oe_n_i),
  .pl_strobe_i (pl_strobe_i),
  .pl_data_i   (pl_data_i),
  .pad_i       (pad_i),
  .pad_o       (pad_o),
  .pad_oe_o    (pad_oe_o),
  .fb_o        (fb_o)
);

// File: tb/plc_out_cell_tb_top.sv
module plc_out_cell_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_sync = 1'b0, cfg_family = 1'b1, cfg_io = 1'b0, cfg_pol = 1'b1;
  logic [N-1:0] cfg_dis = '0;
  logic [N-1:0] pterm = '0;
  logic         oe_n = 1'b0, pl_strobe = 1'b0, pl_data = 1'b0, pad_in = 1'b0;
  logic         pad_o, pad_oe, fb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  plc_out_cell #(.NUM_TERMS(N)) dut_i (
    .clk(clk), .rst(rst), .cfg_sync_i(cfg_sync), .cfg_family_i(cfg_family),
    .cfg_io_i(cfg_io), .cfg_pol_i(cfg_pol), .cfg_pt_dis_i(cfg_dis),
    .pterm_i(pterm), .oe_n_i(oe_n), .pl_strobe_i(pl_strobe), .pl_data_i(pl_data),
    .pad_i(pad_in), .pad_o(pad_o), .pad_oe_o(pad_oe), .fb_o(fb)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  function automatic logic model(input logic [N-1:0] t, input logic [N-1:0] d,
                                 input logic p, input int first);
    logic s = 1'b0;
    for (int i = first; i < N; i++) s = s | (t[i] & ~d[i]);
    return p ? s : ~s;
  endfunction

  task automatic configure(input logic sy, input logic fam, input logic io,
                           input logic p, input logic [N-1:0] d);
    cfg_sync = sy; cfg_family = fam; cfg_io = io; cfg_pol = p; cfg_dis = d;
    pl_strobe = 1'b0; pterm = '0;
    rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic reg_step(input logic [N-1:0] t, input string req);
    pterm = t;
    @(posedge clk); #1;
    chk(req, pad_o, model(t, cfg_dis, cfg_pol, 0));
  endtask

  task automatic t_reset_state;
    configure(1'b0, 1'b1, 1'b0, 1'b0, '0);
    oe_n = 1'b0;
    chk("R1 reg zero after reset", pad_o, 1'b0);
    chk("R8 fb follows reg after reset", fb, 1'b0);
  endtask

  task automatic t_reg_patterns;
    logic [N-1:0] pats [5] = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'h24};
    for (int p = 0; p < 2; p++) begin
      configure(1'b0, 1'b1, 1'b0, p[0], '0);
      foreach (pats[k]) begin
        reg_step(pats[k], p[0] ? "R2 R3 active-high sum" : "R2 R3 active-low sum");
        chk("R8 reg feedback", fb, pad_o);
      end
    end
  endtask

  task automatic t_reg_disable;
    configure(1'b0, 1'b1, 1'b0, 1'b1, 8'h0F);
    reg_step(8'h0F, "R4 masked terms only");
    chk("R4 masked low terms give 0", pad_o, 1'b0);
    reg_step(8'h10, "R4 unmasked term");
    chk("R4 unmasked term gives 1", pad_o, 1'b1);
  endtask

  task automatic t_reg_oe;
    configure(1'b0, 1'b1, 1'b0, 1'b1, '0);
    oe_n = 1'b0; #1;
    chk("R5 oe asserted", pad_oe, 1'b1);
    oe_n = 1'b1; #1;
    chk("R5 oe deasserted", pad_oe, 1'b0);
    oe_n = 1'b0; #1;
    chk("R5 oe asserted again", pad_oe, 1'b1);
  endtask

  task automatic t_comb;
    configure(1'b0, 1'b1, 1'b1, 1'b1, '0);
    pterm = 8'h01; #1;
    chk("R7 term0 enables", pad_oe, 1'b1);
    chk("R6 term0 not in sum", pad_o, 1'b0);
    chk("R8 driven fb", fb, 1'b0);
    pterm = 8'h03; #1;
    chk("R6 term1 in sum", pad_o, 1'b1);
    chk("R8 driven fb high", fb, 1'b1);
    pterm = 8'h82; pad_in = 1'b0; #1;
    chk("R7 no enable", pad_oe, 1'b0);
    chk("R6 term7 in sum", pad_o, model(8'h82, '0, 1'b1, 1));
    chk("R8 undriven fb low", fb, 1'b0);
    pad_in = 1'b1; #1;
    chk("R8 undriven fb high", fb, 1'b1);
    configure(1'b0, 1'b1, 1'b1, 1'b0, 8'h01);
    pterm = 8'h01; #1;
    chk("R7 disabled enable term", pad_oe, 1'b0);
    chk("R3 comb active-low", pad_o, 1'b1);
    pterm = 8'h41; #1;
    chk("R3 comb active-low live", pad_o, 1'b0);
    pad_in = 1'b0;
  endtask

  task automatic t_preload;
    configure(1'b0, 1'b1, 1'b0, 1'b1, '0);
    pterm = 8'h00; pl_data = 1'b1; pl_strobe = 1'b1;
    @(posedge clk); #1;
    chk("R9 preload 1 over sum 0", pad_o, 1'b1);
    pl_strobe = 1'b0;
    @(posedge clk); #1;
    chk("R9 normal after preload", pad_o, 1'b0);
    pterm = 8'hFF; pl_data = 1'b0; pl_strobe = 1'b1;
    @(posedge clk); #1;
    chk("R9 preload 0 over sum 1", pad_o, 1'b0);
    pl_strobe = 1'b0;
    @(posedge clk); #1;
    chk("R9 normal resumes", pad_o, 1'b1);
  endtask

  task automatic t_cfg_ignored;
    configure(1'b0, 1'b1, 1'b0, 1'b1, '0);
    cfg_pol = 1'b0; cfg_io = 1'b1; cfg_dis = 8'hFF; cfg_sync = 1'b1;
    oe_n = 1'b0;
    pterm = 8'h80;
    @(posedge clk); #1;
    chk("R10 late cfg ignored value", pad_o, 1'b1);
    oe_n = 1'b1; #1;
    chk("R10 still registered oe", pad_oe, 1'b0);
    oe_n = 1'b0;
  endtask

  task automatic t_off;
    configure(1'b1, 1'b1, 1'b0, 1'b1, '0);
    pterm = 8'hFF; pad_in = 1'b1;
    @(posedge clk); #1;
    chk("R11 sync set not driven", pad_oe, 1'b0);
    chk("R11 sync set pad 0", pad_o, 1'b0);
    chk("R11 sync set fb pin", fb, 1'b1);
    configure(1'b0, 1'b0, 1'b1, 1'b1, '0);
    pterm = 8'h01; pad_in = 1'b0;
    @(posedge clk); #1;
    chk("R11 family clear not driven", pad_oe, 1'b0);
    chk("R11 family clear fb pin", fb, 1'b0);
  endtask

  initial begin
    t_reset_state();
    t_reg_patterns();
    t_reg_disable();
    t_reg_oe();
    t_comb();
    t_preload();
    t_cfg_ignored();
    t_off();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule